// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block runs the entry sequence that a small 8-bit processor core uses for reset, a non-maskable interrupt, a maskable interrupt and the software break instruction. All four sources share one microsequence. It lasts seven clock cycles and is built on the break opcode: a dummy opcode read, a dummy read of the following byte, three stack pushes and a two-byte vector fetch. The core hands over its program counter, stack pointer and status byte. The block drives the bus cycles and returns the new program counter, the stack pointer after three decrements and the interrupt-disable flag to load.

A reset entry sequences the same pushes with the bus kept in read. Memory stays untouched and the stack pointer still ends three lower. The status byte that is pushed carries a marker bit, so a handler on the shared maskable vector can tell a break from a hardware request. While the reset line is held low, sequences repeat back to back. The vector bytes come from whatever memory answers on `rdata`.

States: `ST_IDLE`, `ST_DUMMY_OP`, `ST_DUMMY_SIG`, `ST_PUSH_HI`, `ST_PUSH_LO`, `ST_PUSH_P`, `ST_VEC_LO` and `ST_VEC_HI`. Transitions:
- `ST_IDLE` goes to `ST_DUMMY_OP` on an accepted request.
- Each push or fetch state steps to the next state in the list above.
- `ST_VEC_HI` goes to `ST_DUMMY_OP` (chain) when reset was low during the sequence, and to `ST_IDLE` otherwise.

Top module: `intr_entry_seq`

## Requirements
- R1: An accepted request makes `busy` high for exactly 7 cycles. During those cycles the addresses are: opcode address, opcode address + 1, three stack addresses, vector, vector + 1.
- R2: A non-reset entry writes three bytes (`rw`=0), in this order: return high at 0x01SS, return low at 0x01(SS-1), status at 0x01(SS-2), where SS is `sp_in` at acceptance. In the seventh cycle `sp_out` = SS-3.
- R3: A reset entry keeps `rw`=1 for all 7 cycles, on the same addresses, and still ends with `sp_out` = SS-3.
- R4: After `por_n`, the outputs are idle: `busy`=0, `done`=0, `rw`=1, `addr`=0, `sp_out`=0, `pc_out`=0. A reset entry from a stack pointer of 0x00 ends with `sp_out`=0xFD.
- R5: `i_out` is 1 in the seventh (`done`) cycle of every entry. Otherwise it follows `i_flag`.
- R6: `nmi_n` is falling-edge sensitive. A line held low gives exactly one entry, and a new falling edge gives another.
- R7: `irq_n` is level sensitive and masked while `i_flag`=1. A line held low with the mask clear re-enters after each idle cycle.
- R8: Priority is reset > NMI > break > IRQ.
- R9: Vectors are 0xFFFC/0xFFFD for reset, 0xFFFA/0xFFFB for NMI, and 0xFFFE/0xFFFF for break and IRQ. `pc_out` = {byte at vector+1, byte at vector} in the `done` cycle.
- R10: The pushed status is `p_in` with bit 5 forced to 1. Bit 4 is 1 for a break entry and 0 for NMI or IRQ.
- R11: NMI, IRQ and break are accepted only while `boundary`=1. Reset is accepted regardless of `boundary`.
- R12: A sequence during which reset is low in any cycle is followed at once by another reset sequence. Holding reset for L sampled edges from idle gives floor((L+5)/7)+1 sequences.
- R13: The return address is `pc_in`+2 (modulo 2^16) for break and `pc_in` for hardware entries. Chained reset sequences reuse the stack pointer captured at the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on clear, active low, asynchronous |
| res_n | input | 1 | Reset request line, active low, level |
| nmi_n | input | 1 | Non-maskable request, active low, falling edge |
| irq_n | input | 1 | Maskable request, active low, level |
| brk_op | input | 1 | Core has fetched the break opcode at `pc_in` |
| boundary | input | 1 | Core is at an instruction boundary |
| i_flag | input | 1 | Current interrupt-disable flag |
| pc_in | input | 16 | Next-instruction address, or the break opcode address |
| sp_in | input | 8 | Current stack pointer |
| p_in | input | 8 | Current status byte |
| rdata | input | 8 | Read data from memory |
| addr | output | 16 | Bus address |
| wdata | output | 8 | Bus write data |
| rw | output | 1 | 1 = read, 0 = write |
| sp_out | output | 8 | Working stack pointer; final value in the `done` cycle |
| pc_out | output | 16 | Loaded vector, valid in the `done` cycle |
| i_out | output | 1 | Interrupt-disable flag to load |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | Seventh cycle of a sequence |

## Verification
The bench drives requests at the falling clock edge, so the next rising edge accepts them. The k-th bus cycle of the entry is then due in the k-th cycle after that edge. `done`, `pc_out` and the final `sp_out` are due in the seventh cycle, and `busy` falls in the eighth. Every check samples at a falling edge counted from the accepting edge, so each sweep point compares all seven cycles field by field. Edge detection, masking, priority and reset chaining are judged by counting `busy` and `done` cycles over a fixed window. The expected totals follow from the 7-cycle length plus one idle cycle between level-held entries.

// File: rtl/ies_pkg.sv
package ies_pkg;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int STAT_BRK = 4;
    localparam int STAT_ONE = 5;
    localparam logic [DATA_W-1:0] STACK_PAGE = 8'h01;
    localparam logic [ADDR_W-1:0] VEC_NMI = 16'hFFFA;
    localparam logic [ADDR_W-1:0] VEC_RST = 16'hFFFC;
    localparam logic [ADDR_W-1:0] VEC_IRQ = 16'hFFFE;
    localparam logic [ADDR_W-1:0] BRK_SKIP = 16'd2;

    typedef enum logic [1:0] {
        SRC_RESET,
        SRC_NMI,
        SRC_BREAK,
        SRC_IRQ
    } src_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DUMMY_OP,
        ST_DUMMY_SIG,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_P,
        ST_VEC_LO,
        ST_VEC_HI
    } state_e;
endpackage

// File: rtl/ies_req_qual.sv
module ies_req_qual
    import ies_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic res_n,
    input  logic nmi_n,
    input  logic irq_n,
    input  logic brk_op,
    input  logic boundary,
    input  logic i_flag,
    input  logic take,
    output logic req,
    output src_e src
);
    logic nmi_q;
    logic nmi_pend;
    logic nmi_fall;
    logic nmi_now;

    assign nmi_fall = nmi_q & ~nmi_n;
    assign nmi_now  = nmi_pend | nmi_fall;

    // Edge memory: a falling edge stays pending until an NMI entry consumes it.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            nmi_q    <= 1'b1;
            nmi_pend <= 1'b0;
        end else begin
            nmi_q    <= nmi_n;
            nmi_pend <= nmi_now & ~(take && src == SRC_NMI);
        end
    end

    // Priority encoder: reset, NMI, break, IRQ.
    always_comb begin
        req = 1'b1;
        src = SRC_RESET;
        if (!res_n) begin
            src = SRC_RESET;
        end else if (boundary && nmi_now) begin
            src = SRC_NMI;
        end else if (boundary && brk_op) begin
            src = SRC_BREAK;
        end else if (boundary && !irq_n && !i_flag) begin
            src = SRC_IRQ;
        end else begin
            req = 1'b0;
            src = SRC_IRQ;
        end
    end

    // R6: an accepted NMI leaves no edge pending behind it.
    p_nmi_consumed_r6: assert property (@(posedge clk) disable iff (!por_n)
        (take && src == SRC_NMI) |=> !nmi_pend);

    // R8: reset is never passed over.
    p_reset_first_r8: assert property (@(posedge clk) disable iff (!por_n)
        (take && !res_n) |-> src == SRC_RESET);
endmodule

// File: rtl/ies_fsm.sv
module ies_fsm
    import ies_pkg::*;
(
    input  logic   clk,
    input  logic   por_n,
    input  logic   req,
    input  logic   res_n,
    output state_e state,
    output logic   take,
    output logic   chain,
    output logic   busy,
    output logic   done
);
    state_e state_nx;
    logic   res_seen;

    assign take  = (state == ST_IDLE) && req;
    assign chain = (state == ST_VEC_HI) && (res_seen || !res_n);
    assign busy  = (state != ST_IDLE);
    assign done  = (state == ST_VEC_HI);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      state_nx = req ? ST_DUMMY_OP : ST_IDLE;
            ST_DUMMY_OP:  state_nx = ST_DUMMY_SIG;
            ST_DUMMY_SIG: state_nx = ST_PUSH_HI;
            ST_PUSH_HI:   state_nx = ST_PUSH_LO;
            ST_PUSH_LO:   state_nx = ST_PUSH_P;
            ST_PUSH_P:    state_nx = ST_VEC_LO;
            ST_VEC_LO:    state_nx = ST_VEC_HI;
            ST_VEC_HI:    state_nx = chain ? ST_DUMMY_OP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Remembers whether reset was low in any cycle of the running sequence.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            res_seen <= 1'b0;
        end else if (state == ST_IDLE || state == ST_VEC_HI) begin
            res_seen <= 1'b0;
        end else begin
            res_seen <= res_seen | ~res_n;
        end
    end

    // R1: the push phase always runs into the vector fetch.
    p_push_to_vec_r1: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_PUSH_P) |=> (state == ST_VEC_LO));

    // R1: the last vector cycle follows the first one.
    p_vec_pair_r1: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_VEC_HI) |-> ($past(state) == ST_VEC_LO));

    // R12: reset still low at the end forces another sequence.
    p_chain_on_hold_r12: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_VEC_HI && !res_n) |=> (state == ST_DUMMY_OP));
endmodule

// File: rtl/ies_frame.sv
module ies_frame
    import ies_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              load,
    input  logic              chain,
    input  src_e              src_in,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] p_in,
    output src_e              src_q,
    output logic [ADDR_W-1:0] pc_base,
    output logic [ADDR_W-1:0] ret_addr,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [DATA_W-1:0] push_stat,
    output logic [DATA_W-1:0] sp_base
);
    logic [DATA_W-1:0] p_q;

    // Context is captured once per chain; a chained reset keeps PC, SP and P.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            src_q   <= SRC_RESET;
            pc_base <= '0;
            sp_base <= '0;
            p_q     <= '0;
        end else if (load) begin
            src_q   <= src_in;
            pc_base <= pc_in;
            sp_base <= sp_in;
            p_q     <= p_in;
        end else if (chain) begin
            src_q   <= SRC_RESET;
        end
    end

    assign ret_addr = (src_q == SRC_BREAK) ? pc_base + BRK_SKIP : pc_base;

    always_comb begin
        push_stat           = p_q;
        push_stat[STAT_ONE] = 1'b1;
        push_stat[STAT_BRK] = (src_q == SRC_BREAK);
    end

    always_comb begin
        unique case (src_q)
            SRC_RESET: vec_addr = VEC_RST;
            SRC_NMI:   vec_addr = VEC_NMI;
            SRC_BREAK: vec_addr = VEC_IRQ;
            SRC_IRQ:   vec_addr = VEC_IRQ;
        endcase
    end
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
    import ies_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              res_n,
    input  logic              nmi_n,
    input  logic              irq_n,
    input  logic              brk_op,
    input  logic              boundary,
    input  logic              i_flag,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] p_in,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              rw,
    output logic [DATA_W-1:0] sp_out,
    output logic [ADDR_W-1:0] pc_out,
    output logic              i_out,
    output logic              busy,
    output logic              done
);
    state_e            state;
    logic              take;
    logic              chain;
    logic              req;
    src_e              src;
    src_e              src_q;
    logic [ADDR_W-1:0] pc_base;
    logic [ADDR_W-1:0] ret_addr;
    logic [ADDR_W-1:0] vec_addr;
    logic [DATA_W-1:0] push_stat;
    logic [DATA_W-1:0] sp_base;
    logic [DATA_W-1:0] pcl_q;
    logic              quiet;

    ies_req_qual u_qual (
        .clk      (clk),
        .por_n    (por_n),
        .res_n    (res_n),
        .nmi_n    (nmi_n),
        .irq_n    (irq_n),
        .brk_op   (brk_op),
        .boundary (boundary),
        .i_flag   (i_flag),
        .take     (take),
        .req      (req),
        .src      (src)
    );

    ies_fsm u_fsm (
        .clk   (clk),
        .por_n (por_n),
        .req   (req),
        .res_n (res_n),
        .state (state),
        .take  (take),
        .chain (chain),
        .busy  (busy),
        .done  (done)
    );

    ies_frame u_frame (
        .clk       (clk),
        .por_n     (por_n),
        .load      (take),
        .chain     (chain),
        .src_in    (src),
        .pc_in     (pc_in),
        .sp_in     (sp_in),
        .p_in      (p_in),
        .src_q     (src_q),
        .pc_base   (pc_base),
        .ret_addr  (ret_addr),
        .vec_addr  (vec_addr),
        .push_stat (push_stat),
        .sp_base   (sp_base)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pcl_q <= '0;
        end else if (state == ST_VEC_LO) begin
            pcl_q <= rdata;
        end
    end

    // Reset entries keep the bus in read during the push cycles.
    assign quiet = (src_q == SRC_RESET);
    assign i_out = i_flag | done;

    // Output process: bus cycle per state.
    always_comb begin
        addr   = '0;
        wdata  = '0;
        rw     = 1'b1;
        sp_out = '0;
        pc_out = '0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_DUMMY_OP: begin
                addr   = pc_base;
                sp_out = sp_base;
            end
            ST_DUMMY_SIG: begin
                addr   = pc_base + 16'd1;
                sp_out = sp_base;
            end
            ST_PUSH_HI: begin
                addr   = {STACK_PAGE, sp_base};
                wdata  = ret_addr[ADDR_W-1:DATA_W];
                rw     = quiet;
                sp_out = sp_base;
            end
            ST_PUSH_LO: begin
                addr   = {STACK_PAGE, sp_base - 8'd1};
                wdata  = ret_addr[DATA_W-1:0];
                rw     = quiet;
                sp_out = sp_base - 8'd1;
            end
            ST_PUSH_P: begin
                addr   = {STACK_PAGE, sp_base - 8'd2};
                wdata  = push_stat;
                rw     = quiet;
                sp_out = sp_base - 8'd2;
            end
            ST_VEC_LO: begin
                addr   = vec_addr;
                sp_out = sp_base - 8'd3;
            end
            ST_VEC_HI: begin
                addr   = vec_addr | 16'h0001;
                sp_out = sp_base - 8'd3;
                pc_out = {rdata, pcl_q};
            end
        endcase
    end

    // R3: no write cycle in a reset entry.
    p_reset_quiet_r3: assert property (@(posedge clk) disable iff (!por_n)
        (busy && src_q == SRC_RESET) |-> rw);

    // R2: every write lands in the stack page.
    p_write_stack_r2: assert property (@(posedge clk) disable iff (!por_n)
        !rw |-> (addr[ADDR_W-1:DATA_W] == STACK_PAGE));

    // R2: final SP is one below the status push address two cycles earlier.
    p_sp_final_r2: assert property (@(posedge clk) disable iff (!por_n)
        done |-> (sp_out == $past(addr[DATA_W-1:0], 2) - 8'd1));

    // R9: the last cycle reads the odd byte of a top-page vector.
    p_vec_odd_r9: assert property (@(posedge clk) disable iff (!por_n)
        done |-> (addr[ADDR_W-1:3] == '1 && addr[0]));

    // R11: a start with reset released needs an instruction boundary.
    p_gated_start_r11: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(busy) && $past(res_n)) |-> $past(boundary));
endmodule

// File: tb/intr_entry_seq_tb_top.sv
`timescale 1ns/1ps
module intr_entry_seq_tb_top;
    logic        clk = 1'b0;
    logic        por_n, res_n, nmi_n, irq_n, brk_op, boundary, i_flag;
    logic [15:0] pc_in;
    logic [7:0]  sp_in, p_in, rdata;
    logic [15:0] addr, pc_out;
    logic [7:0]  wdata, sp_out;
    logic        rw, i_out, busy, done;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;

    always #2 clk = ~clk;

    // Memory model: every byte reads as the complement of its address low byte.
    assign rdata = ~addr[7:0];

    intr_entry_seq dut_i (
        .clk(clk), .por_n(por_n), .res_n(res_n), .nmi_n(nmi_n), .irq_n(irq_n),
        .brk_op(brk_op), .boundary(boundary), .i_flag(i_flag), .pc_in(pc_in),
        .sp_in(sp_in), .p_in(p_in), .rdata(rdata), .addr(addr), .wdata(wdata),
        .rw(rw), .sp_out(sp_out), .pc_out(pc_out), .i_out(i_out), .busy(busy),
        .done(done)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            summary();
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic release_all();
        res_n = 1'b1; nmi_n = 1'b1; irq_n = 1'b1; brk_op = 1'b0; boundary = 1'b0;
    endtask

    function automatic logic [15:0] vec_of(input int kd);
        return (kd == 0) ? 16'hFFFC : (kd == 1) ? 16'hFFFA : 16'hFFFE;
    endfunction

    function automatic logic [15:0] vec_data(input logic [15:0] v);
        return {~(v[7:0] | 8'h01), ~v[7:0]};
    endfunction

    // kd: 0 reset, 1 NMI, 2 break, 3 IRQ
    task automatic run_one(input int kd, input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] p);
        logic [15:0] ret, vec;
        logic [7:0]  st;
        logic [51:0] got, exp;
        ret = (kd == 2) ? pc + 16'd2 : pc;
        vec = vec_of(kd);
        st  = {p[7:6], 1'b1, (kd == 2), p[3:0]};
        @(negedge clk);
        pc_in = pc; sp_in = sp; p_in = p; i_flag = 1'b0;
        boundary = (kd != 0);
        case (kd)
            0: res_n = 1'b0;
            1: nmi_n = 1'b0;
            2: brk_op = 1'b1;
            default: irq_n = 1'b0;
        endcase
        @(negedge clk);
        release_all();
        for (int c = 0; c < 7; c++) begin
            logic [15:0] ea, epc;
            logic [7:0]  ewd, esp;
            logic        erw;
            string       tag;
            ea = 16'h0; ewd = 8'h00; erw = 1'b1; esp = sp; epc = 16'h0;
            case (c)
                0: begin ea = pc; tag = "R1 dummy opcode"; end
                1: begin ea = pc + 16'd1; tag = "R1 dummy signature"; end
                2: begin ea = {8'h01, sp}; erw = (kd == 0); ewd = ret[15:8];
                         tag = (kd == 0) ? "R3 quiet push hi" : "R2 R13 push ret hi"; end
                3: begin ea = {8'h01, sp - 8'd1}; erw = (kd == 0); ewd = ret[7:0]; esp = sp - 8'd1;
                         tag = (kd == 0) ? "R3 quiet push lo" : "R2 R13 push ret lo"; end
                4: begin ea = {8'h01, sp - 8'd2}; erw = (kd == 0); ewd = st; esp = sp - 8'd2;
                         tag = (kd == 0) ? "R3 quiet push status" : "R2 R10 push status"; end
                5: begin ea = vec; esp = sp - 8'd3; tag = "R9 vector low"; end
                default: begin ea = vec | 16'h0001; esp = sp - 8'd3; epc = vec_data(vec);
                         tag = "R9 R5 R2 R3 vector high"; end
            endcase
            if (erw) ewd = 8'h00;
            got = {addr, rw, busy, done, sp_out, i_out, (rw ? 8'h00 : wdata), (done ? pc_out : 16'h0)};
            exp = {ea, erw, 1'b1, (c == 6), esp, (c == 6), ewd, epc};
            check(got == exp, $sformatf("%s kind %0d cycle %0d", tag, kd, c), 64'(got), 64'(exp));
            @(negedge clk);
        end
        check(busy == 1'b0, "R1 busy low after seven cycles", 64'(busy), 64'd0);
    endtask

    // Reset held for L sampled edges from idle; counts sequences.
    task automatic chain_run(input int L);
        int          nb, nd, n_exp;
        logic [7:0]  lsp;
        nb = 0; nd = 0; lsp = 8'h00;
        n_exp = (L + 5) / 7 + 1;
        @(negedge clk);
        sp_in = 8'h00; pc_in = 16'h1234; p_in = 8'h00; res_n = 1'b0; boundary = 1'b0;
        for (int k = 0; k < L; k++) begin
            @(negedge clk);
            if (busy) nb++;
            if (done) begin nd++; lsp = sp_out; end
        end
        res_n = 1'b1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (!busy) break;
            nb++;
            if (done) begin nd++; lsp = sp_out; end
        end
        check(nd == n_exp, $sformatf("R12 sequence count hold %0d", L), 64'(nd), 64'(n_exp));
        check(nb == 7 * n_exp, $sformatf("R12 busy cycles hold %0d", L), 64'(nb), 64'(7 * n_exp));
        check(lsp == 8'hFD, $sformatf("R4 R13 final sp hold %0d", L), 64'(lsp), 64'hFD);
    endtask

    task automatic prio(input bit r, input bit n, input bit b, input bit i,
                        input logic [15:0] epc, input bit chk_st, input bit ebit4, input string tag);
        logic [15:0] gpc;
        logic [7:0]  gst;
        gpc = 16'h0; gst = 8'h00;
        @(negedge clk);
        pc_in = 16'h2000; sp_in = 8'hF0; p_in = 8'h00; i_flag = 1'b0; boundary = 1'b1;
        res_n = ~r; nmi_n = ~n; brk_op = b; irq_n = ~i;
        @(negedge clk);
        release_all();
        for (int k = 0; k < 10; k++) begin
            if (!rw && addr == 16'h01EE) gst = wdata;
            if (done) begin gpc = pc_out; break; end
            @(negedge clk);
        end
        check(gpc == epc, {tag, " vector"}, 64'(gpc), 64'(epc));
        if (chk_st) check(gst[4] == ebit4, {tag, " R10 bit4"}, 64'(gst[4]), 64'(ebit4));
        @(negedge clk);
    endtask

    task automatic count_busy(input int len, output int nb);
        nb = 0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            if (busy) nb++;
        end
    endtask

    initial begin
        int nb, nd, nw;
        logic [15:0] p1, p2;
        logic [7:0] pv [4];
        por_n = 1'b0; release_all(); i_flag = 1'b1;
        pc_in = 16'h0; sp_in = 8'h0; p_in = 8'h0;
        pv[0] = 8'h00; pv[1] = 8'hFF; pv[2] = 8'h35; pv[3] = 8'hCA;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        check({busy, done, rw, addr, sp_out, pc_out, i_out} == {3'b001, 16'h0, 8'h0, 16'h0, 1'b1},
              "R4 R5 idle after power-on",
              64'({busy, done, rw, addr, sp_out, pc_out, i_out}), 64'({3'b001, 41'h0, 1'b1}));

        // Power-up style reset from SP 0x00.
        chain_run(1);

        // Sweep of kinds, stack pointers, status values, addresses.
        for (int kd = 0; kd < 4; kd++)
            for (int s = 0; s < 8; s++)
                for (int q = 0; q < 4; q++)
                    run_one(kd, (s == 7) ? 16'hFFFF : 16'(kd * 16'h4000 + s * 16'h0913 + q),
                            8'(s * 37 + q), pv[q]);

        // R12 chain length sweep.
        for (int L = 1; L <= 20; L++) chain_run(L);

        // R8 priority.
        prio(1, 1, 1, 1, 16'h0203, 0, 0, "R8 reset over all");
        prio(0, 1, 1, 1, 16'h0405, 1, 0, "R8 NMI over break and IRQ");
        prio(0, 0, 1, 1, 16'h0001, 1, 1, "R8 break over IRQ");
        prio(0, 0, 0, 1, 16'h0001, 1, 0, "R8 IRQ alone");

        // R6 NMI held low: one entry; new edge: one more.
        @(negedge clk); nmi_n = 1'b0; boundary = 1'b1; i_flag = 1'b0;
        count_busy(20, nb);
        check(nb == 7, "R6 NMI held low gives one entry", 64'(nb), 64'd7);
        nmi_n = 1'b1;
        @(negedge clk); nmi_n = 1'b0;
        count_busy(20, nb);
        check(nb == 7, "R6 second falling edge gives one entry", 64'(nb), 64'd7);
        release_all();

        // R7 IRQ masked, then unmasked level re-entry.
        @(negedge clk); irq_n = 1'b0; boundary = 1'b1; i_flag = 1'b1;
        count_busy(15, nb);
        check(nb == 0, "R7 IRQ masked by i_flag", 64'(nb), 64'd0);
        check(i_out == 1'b1, "R5 i_out follows i_flag when idle", 64'(i_out), 64'd1);
        i_flag = 1'b0;
        count_busy(16, nb);
        check(nb == 14, "R7 IRQ level re-enters after idle cycle", 64'(nb), 64'd14);
        release_all();
        repeat (8) @(negedge clk);

        // R11 IRQ and break without boundary ignored.
        @(negedge clk); irq_n = 1'b0; brk_op = 1'b1; boundary = 1'b0; i_flag = 1'b0;
        count_busy(12, nb);
        check(nb == 0, "R11 no entry off boundary", 64'(nb), 64'd0);
        release_all();

        // R12 reset arriving during an IRQ entry.
        @(negedge clk); pc_in = 16'h3000; sp_in = 8'h80; irq_n = 1'b0; boundary = 1'b1;
        @(negedge clk); release_all();
        nd = 0; nw = 0; p1 = 16'h0; p2 = 16'h0;
        for (int k = 0; k < 40; k++) begin
            if (k == 2) res_n = 1'b0;
            if (k == 3) res_n = 1'b1;
            if (!rw) nw++;
            if (done) begin if (nd == 0) p1 = pc_out; else p2 = pc_out; nd++; end
            @(negedge clk);
            if (!busy) break;
        end
        check(nd == 2, "R12 reset during IRQ adds one sequence", 64'(nd), 64'd2);
        check({p1, p2} == {16'h0001, 16'h0203}, "R12 R9 IRQ then reset vectors",
              64'({p1, p2}), 64'({16'h0001, 16'h0203}));
        check(nw == 3, "R2 R3 only the IRQ pushes write", 64'(nw), 64'd3);

        summary();
    end
endmodule